// File: doc/BRIEF.md
# Clock-Crossing Memory-Mapped Register Bridge

This block is a memory-mapped bus slave with a 32-bit data path that runs on a CPU clock. It turns each single bus command into an access on a simple register port that runs on an unrelated user clock. A write shows up on the register side as a one-cycle strobe, together with the word address, the write data and the byte enables. A read shows up as a one-cycle request pulse with an address. The address is then held steady until the register slave answers with a read-valid pulse and its data, and that data is carried back to the bus.

Only one command is in flight at a time. The bus wait-request output stays high from the moment a command is seen until its completion has crossed back into the CPU domain. Every handover between the two domains uses a request toggle and an acknowledge toggle, each passed through a two-flop synchronizer. The multi-bit fields are captured only after the matching toggle has been seen. Because the slave's read latency is measured by its own handshake, the slave may answer in the same cycle as the request or many cycles later.

Top module: `avmm_reg_bridge`

## Requirements
- R1: After reset, `avs_waitrequest` is 1. It stays 1 from the first cycle in which `avs_write` or `avs_read` is seen by an idle bridge until the command completes.
- R2: Each bus write produces exactly one user-clock cycle with `reg_wr_en`=1. In that cycle `reg_addr`, `reg_wr_data` and `reg_wr_be` equal the bus address, write data and byte enables of that command.
- R3: `reg_wr_be` has 4 bits, and bit n qualifies `reg_wr_data[8n+7:8n]`. An all-zero byte enable still produces the write strobe, but it leaves the addressed register unchanged.
- R4: Each bus read produces exactly one user-clock cycle with `reg_rd_req`=1. `reg_addr` carries the bus word address in that cycle and holds that value until the cycle in which `reg_rd_valid` is 1.
- R5: For a read, `avs_readdata` equals the `reg_rd_data` value that was present with `reg_rd_valid`, and it is valid in the cycle in which `avs_waitrequest` is 0.
- R6: Each bus command produces exactly one register-side strobe (a write strobe or a read request), in issue order. While a command is outstanding, its captured address, data and kind do not change.
- R7: A read completes correctly for any slave latency, including a `reg_rd_valid` in the same cycle as `reg_rd_req`.
- R8: `reg_wr_en` and `reg_rd_req` are never 1 in the same cycle, and neither stays high for two cycles in a row.
- R9: `avs_waitrequest` goes to 0 for exactly one CPU cycle per command and then returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-domain clock |
| cpu_rst | input | 1 | Synchronous active-high reset, CPU domain |
| avs_address | input | ADDR_W | Word address of the bus command |
| avs_write | input | 1 | Bus write command |
| avs_read | input | 1 | Bus read command |
| avs_writedata | input | DATA_W | Bus write data |
| avs_byteenable | input | DATA_W/8 | Bus byte enables |
| avs_readdata | output | DATA_W | Read data returned to the bus |
| avs_waitrequest | output | 1 | High while a command must be held |
| usr_clk | input | 1 | User-domain clock |
| usr_rst | input | 1 | Synchronous active-high reset, user domain |
| reg_addr | output | ADDR_W | Register word address shared by reads and writes |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | DATA_W | Register write data |
| reg_wr_be | output | DATA_W/8 | Register byte enables |
| reg_rd_req | output | 1 | One-cycle read request |
| reg_rd_valid | input | 1 | Slave marks read data valid |
| reg_rd_data | input | DATA_W | Read data from the slave |

## Verification
If the toggle bookkeeping goes wrong, the ports show it as a missing, doubled or reordered register strobe. It can also show as a wait-request that never drops, which appears within one handshake round trip (a few cycles of each clock) of the bad command. If a captured field changes while its command is outstanding, the register side sees a wrong address, data or byte-enable value at the strobe. A read path that samples the response too early returns data that differs from the slave's content, and this shows in the one CPU cycle in which wait-request is low. The bench therefore compares every strobe against a queue of issued commands and every read against a model memory, over slave latencies from zero to several cycles.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    // CPU-side command progress
    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_WAIT = 2'd1,
        C_DONE = 2'd2
    } cpu_state_e;

    // User-side register access progress
    typedef enum logic {
        U_IDLE = 1'b0,
        U_RD   = 1'b1
    } usr_state_e;

endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end else begin : g_single
            always_comb sh_d = d;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/bridge_cpu_side.sv
module bridge_cpu_side
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] avs_address,
    input  logic              avs_write,
    input  logic              avs_read,
    input  logic [DATA_W-1:0] avs_writedata,
    input  logic [DATA_W/8-1:0] avs_byteenable,
    output logic [DATA_W-1:0] avs_readdata,
    output logic              avs_waitrequest,
    output logic              req_tgl,
    output logic              req_is_wr,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W/8-1:0] req_be,
    input  logic              ack_sync,
    input  logic [DATA_W-1:0] rsp_rdata
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        cpu_state_e        st;
        logic              req_tgl;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] rdata;
    } cpu_regs_t;

    cpu_regs_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            C_IDLE: begin
                if (avs_write || avs_read) begin
                    d.is_wr   = avs_write;
                    d.addr    = avs_address;
                    d.wdata   = avs_writedata;
                    d.be      = avs_byteenable;
                    d.req_tgl = ~q.req_tgl;
                    d.st      = C_WAIT;
                end
            end
            C_WAIT: begin
                // acknowledge toggle caught up with request toggle
                if (ack_sync == q.req_tgl) begin
                    if (!q.is_wr) d.rdata = rsp_rdata;
                    d.st = C_DONE;
                end
            end
            C_DONE:  d.st = C_IDLE;
            default: d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st      <= C_IDLE;
            q.req_tgl <= 1'b0;
            q.is_wr   <= 1'b0;
            q.addr    <= '0;
            q.wdata   <= '0;
            q.be      <= '0;
            q.rdata   <= '0;
        end else begin
            q <= d;
        end
    end

    assign avs_waitrequest = (q.st != C_DONE);
    assign avs_readdata    = q.rdata;
    assign req_tgl         = q.req_tgl;
    assign req_is_wr       = q.is_wr;
    assign req_addr        = q.addr;
    assign req_wdata       = q.wdata;
    assign req_be          = q.be;

    // R1
    cmd_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        ((avs_write || avs_read) && q.st == C_IDLE) |=> avs_waitrequest);

    // R9
    wait_low_once_chk: assert property (@(posedge clk) disable iff (rst)
        !avs_waitrequest |=> avs_waitrequest);

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == C_WAIT) |=> ($stable(q.addr) && $stable(q.wdata) &&
                              $stable(q.be) && $stable(q.is_wr)));
endmodule

// File: rtl/bridge_usr_side.sv
module bridge_usr_side
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_sync,
    input  logic              req_is_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic              ack_tgl,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W/8-1:0] reg_wr_be,
    output logic              reg_rd_req,
    input  logic              reg_rd_valid,
    input  logic [DATA_W-1:0] reg_rd_data
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        usr_state_e        st;
        logic              ack_tgl;
        logic              wr_en;
        logic              rd_req;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] rdata;
    } usr_regs_t;

    usr_regs_t q, d;

    always_comb begin
        d        = q;
        d.wr_en  = 1'b0;
        d.rd_req = 1'b0;
        unique case (q.st)
            U_IDLE: begin
                // a request is pending while the toggles disagree
                if (req_sync != q.ack_tgl) begin
                    d.addr = req_addr;
                    if (req_is_wr) begin
                        d.wr_en   = 1'b1;
                        d.wdata   = req_wdata;
                        d.be      = req_be;
                        d.ack_tgl = ~q.ack_tgl;
                    end else begin
                        d.rd_req = 1'b1;
                        d.st     = U_RD;
                    end
                end
            end
            U_RD: begin
                if (reg_rd_valid) begin
                    d.rdata   = reg_rd_data;
                    d.ack_tgl = ~q.ack_tgl;
                    d.st      = U_IDLE;
                end
            end
            default: d.st = U_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st      <= U_IDLE;
            q.ack_tgl <= 1'b0;
            q.wr_en   <= 1'b0;
            q.rd_req  <= 1'b0;
            q.addr    <= '0;
            q.wdata   <= '0;
            q.be      <= '0;
            q.rdata   <= '0;
        end else begin
            q <= d;
        end
    end

    assign ack_tgl     = q.ack_tgl;
    assign rsp_rdata   = q.rdata;
    assign reg_addr    = q.addr;
    assign reg_wr_en   = q.wr_en;
    assign reg_wr_data = q.wdata;
    assign reg_wr_be   = q.be;
    assign reg_rd_req  = q.rd_req;

    // R8
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_en && reg_rd_req));

    // R2
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd_req |=> !reg_rd_req);

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == U_RD && !reg_rd_valid) |=> $stable(reg_addr));
endmodule

// File: rtl/avmm_reg_bridge.sv
module avmm_reg_bridge #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                cpu_clk,
    input  logic                cpu_rst,
    input  logic [ADDR_W-1:0]   avs_address,
    input  logic                avs_write,
    input  logic                avs_read,
    input  logic [DATA_W-1:0]   avs_writedata,
    input  logic [DATA_W/8-1:0] avs_byteenable,
    output logic [DATA_W-1:0]   avs_readdata,
    output logic                avs_waitrequest,
    input  logic                usr_clk,
    input  logic                usr_rst,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic                reg_wr_en,
    output logic [DATA_W-1:0]   reg_wr_data,
    output logic [DATA_W/8-1:0] reg_wr_be,
    output logic                reg_rd_req,
    input  logic                reg_rd_valid,
    input  logic [DATA_W-1:0]   reg_rd_data
);
    localparam int BE_W = DATA_W / 8;

    logic              req_tgl, req_sync, ack_tgl, ack_sync, req_is_wr;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata, rsp_rdata;
    logic [BE_W-1:0]   req_be;

    bridge_cpu_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cpu (
        .clk(cpu_clk), .rst(cpu_rst),
        .avs_address(avs_address), .avs_write(avs_write), .avs_read(avs_read),
        .avs_writedata(avs_writedata), .avs_byteenable(avs_byteenable),
        .avs_readdata(avs_readdata), .avs_waitrequest(avs_waitrequest),
        .req_tgl(req_tgl), .req_is_wr(req_is_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .ack_sync(ack_sync), .rsp_rdata(rsp_rdata)
    );

    bridge_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(usr_clk), .rst(usr_rst), .d(req_tgl), .q(req_sync)
    );

    bridge_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(cpu_clk), .rst(cpu_rst), .d(ack_tgl), .q(ack_sync)
    );

    bridge_usr_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_usr (
        .clk(usr_clk), .rst(usr_rst),
        .req_sync(req_sync), .req_is_wr(req_is_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .ack_tgl(ack_tgl), .rsp_rdata(rsp_rdata),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_wr_be(reg_wr_be), .reg_rd_req(reg_rd_req),
        .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data)
    );
endmodule

// File: tb/avmm_reg_bridge_bench.sv
module avmm_reg_bridge_bench;
    localparam int AW = 8;
    localparam int DW = 32;

    logic cpu_clk = 1'b0, usr_clk = 1'b0;
    logic cpu_rst = 1'b1, usr_rst = 1'b1;
    always #10 cpu_clk = ~cpu_clk;   // 50 MHz
    always #7  usr_clk = ~usr_clk;

    logic [AW-1:0] avs_address = '0;
    logic          avs_write = 1'b0, avs_read = 1'b0;
    logic [DW-1:0] avs_writedata = '0;
    logic [3:0]    avs_byteenable = '0;
    logic [DW-1:0] avs_readdata;
    logic          avs_waitrequest;
    logic [AW-1:0] reg_addr;
    logic          reg_wr_en, reg_rd_req, reg_rd_valid;
    logic [DW-1:0] reg_wr_data, reg_rd_data;
    logic [3:0]    reg_wr_be;

    avmm_reg_bridge u_avmm_reg_bridge (
        .cpu_clk(cpu_clk), .cpu_rst(cpu_rst),
        .avs_address(avs_address), .avs_write(avs_write), .avs_read(avs_read),
        .avs_writedata(avs_writedata), .avs_byteenable(avs_byteenable),
        .avs_readdata(avs_readdata), .avs_waitrequest(avs_waitrequest),
        .usr_clk(usr_clk), .usr_rst(usr_rst),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_wr_be(reg_wr_be), .reg_rd_req(reg_rd_req),
        .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- register slave model ----------------
    logic [DW-1:0] smem [16] = '{default: '0};
    int  lat_cfg = 0;
    bit  pend = 0;
    int  cnt = 0;

    assign reg_rd_valid = pend ? (cnt == 0) : (reg_rd_req && lat_cfg == 0);
    assign reg_rd_data  = smem[reg_addr[3:0]];

    always @(posedge usr_clk) begin
        if (usr_rst) begin
            pend <= 0;
        end else begin
            if (reg_wr_en)
                for (int b = 0; b < 4; b++)
                    if (reg_wr_be[b]) smem[reg_addr[3:0]][8*b +: 8] <= reg_wr_data[8*b +: 8];
            if (reg_rd_req && lat_cfg != 0) begin
                pend <= 1;
                cnt  <= lat_cfg - 1;
            end else if (pend) begin
                if (cnt == 0) pend <= 0;
                else          cnt  <= cnt - 1;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit            wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [3:0]    be;
    } item_t;
    item_t exp_q[$];
    logic [DW-1:0] model [16] = '{default: '0};
    logic [AW-1:0] rd_addr_cap = '0;
    bit rd_open = 0;

    always @(negedge usr_clk) begin
        item_t e;
        if (!usr_rst) begin
            if (reg_wr_en && reg_rd_req)
                check(0, "R8", "write and read strobe together", 1, 0);
            if (reg_wr_en || reg_rd_req) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6", "strobe without command", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(e.wr == reg_wr_en, "R6", "strobe kind", {31'd0, reg_wr_en}, {31'd0, e.wr});
                    check(reg_addr == e.addr, e.wr ? "R2" : "R4", "strobe address",
                          {24'd0, reg_addr}, {24'd0, e.addr});
                    if (e.wr) begin
                        check(reg_wr_data == e.data, "R2", "write data", reg_wr_data, e.data);
                        check(reg_wr_be == e.be, "R3", "byte enables", {28'd0, reg_wr_be}, {28'd0, e.be});
                    end
                end
            end
            if (reg_rd_req) begin
                rd_addr_cap = reg_addr;
                rd_open     = 1;
            end
            if (reg_rd_valid && rd_open) begin
                check(reg_addr == rd_addr_cap, "R4", "address held to read-valid",
                      {24'd0, reg_addr}, {24'd0, rd_addr_cap});
                rd_open = 0;
            end
        end
    end

    // ---------------- bus driver ----------------
    task automatic bus_cmd(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [3:0] be,
                           output logic [DW-1:0] rd);
        int cyc = 0;
        bit first = 1;
        @(negedge cpu_clk);
        avs_address = a; avs_writedata = d; avs_byteenable = be;
        avs_write = wr; avs_read = !wr;
        forever begin
            @(negedge cpu_clk);
            if (first) check(avs_waitrequest == 1, "R1", "wait-request on first cycle",
                             {31'd0, avs_waitrequest}, 1);
            first = 0;
            if (!avs_waitrequest) break;
            cyc++;
            if (cyc > 300) begin
                check(0, "R1", "command never completed", 1, 0);
                break;
            end
        end
        rd = avs_readdata;
        @(negedge cpu_clk);
        avs_write = 0; avs_read = 0;
        check(avs_waitrequest == 1, "R9", "wait-request low for one cycle only",
              {31'd0, avs_waitrequest}, 1);
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d, logic [3:0] be);
        item_t e;
        logic [DW-1:0] dummy;
        e.wr = 1; e.addr = a; e.data = d; e.be = be;
        exp_q.push_back(e);
        for (int b = 0; b < 4; b++)
            if (be[b]) model[a[3:0]][8*b +: 8] = d[8*b +: 8];
        bus_cmd(1, a, d, be, dummy);
    endtask

    task automatic bus_read(logic [AW-1:0] a, int lat, string req);
        item_t e;
        logic [DW-1:0] got;
        e.wr = 0; e.addr = a; e.data = '0; e.be = '0;
        exp_q.push_back(e);
        lat_cfg = lat;
        bus_cmd(0, a, '0, '0, got);
        check(got == model[a[3:0]], req, "read data", got, model[a[3:0]]);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (5) @(negedge cpu_clk);
        cpu_rst = 0;
        @(negedge usr_clk);
        usr_rst = 0;
        repeat (3) @(negedge cpu_clk);
        // reset state: R1, R8, R5
        check(avs_waitrequest == 1, "R1", "reset wait-request", {31'd0, avs_waitrequest}, 1);
        check(reg_wr_en == 0, "R8", "reset write strobe", {31'd0, reg_wr_en}, 0);
        check(reg_rd_req == 0, "R8", "reset read request", {31'd0, reg_rd_req}, 0);
        check(avs_readdata == 0, "R5", "reset read data", avs_readdata, 0);

        // full-word writes, R2
        bus_write(8'd0,   32'h1122_3344, 4'hF);
        bus_write(8'd3,   32'hA5A5_5A5A, 4'hF);
        bus_write(8'd255, 32'hDEAD_BEEF, 4'hF);
        // reads with various slave latencies, R5 and R7
        bus_read(8'd0,   0, "R7");
        bus_read(8'd3,   1, "R7");
        bus_read(8'd255, 4, "R5");
        bus_read(8'd0,   9, "R7");
        // partial byte enables, R3
        bus_write(8'd0, 32'hAABB_CCDD, 4'b0101);
        bus_read(8'd0, 2, "R3");
        bus_write(8'd3, 32'h0102_0304, 4'b1000);
        bus_read(8'd3, 0, "R3");
        bus_write(8'd3, 32'hFFFF_FFFF, 4'b0000);
        bus_read(8'd3, 3, "R3");
        // mixed traffic, R6
        for (int i = 1; i <= 24; i++) begin
            logic [DW-1:0] v;
            v = i * 32'h9E37_79B1;
            if (i % 3 == 0) bus_read(AW'(i * 7), i % 6, "R6");
            else            bus_write(AW'(i * 7), v, 4'(i));
        end
        repeat (10) @(negedge usr_clk);
        check(exp_q.size() == 0, "R6", "commands without strobe", exp_q.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule